// File: doc/BRIEF.md
# Long-Period PWM Segment Sequencer

This controller sits beside a small PWM timer whose period register is too narrow for the output period the system needs. It divides one output period into eight timer segments and, on every period-match event from the timer, writes the period value of the segment that has just begun and the compare (duty) value of the segment after it. Those writes are issued one clock after the event, as single-cycle strobes with their data.

The segment lengths come from a total-period target given in prescaled ticks. The first seven segments take the floor of one eighth of that target. The last segment takes whatever is left, so the eight lengths add up exactly. A high-time target, also in ticks, is laid over these segments. A segment that the pulse runs through gets a compare value above any possible period value, so the timer never clears the output at that segment's rollover. The segment in which the pulse ends gets the leftover tick count. Every later segment gets zero.

The timer's period register takes effect at once, so it is written only just after a match. The timer's compare register is buffered, so each compare value is written one segment before the segment in which it acts. New targets are sampled when segment 7 begins. The first compare value of a period is written at that moment, and the sampled pair then governs every write of the output period that starts at the next match.

Top module: `seg_pwm_sequencer`

## Requirements
- R1: While reset is asserted and until the first match after it, both write strobes are low and the segment index reads 7.
- R2: Each cycle in which `seg_match` is high produces exactly one cycle with both `per_wr` and `duty_wr` high, in the next cycle. In any cycle that does not follow a match, both strobes are low, and `per_val` and `duty_val` hold their last written values.
- R3: The segment index `seg_idx` rises by one on each match and wraps from 7 to 0. It is otherwise stable.
- R4: Take P as the active total period and b = floor(P/8). At the match that begins segment s, `per_val` is written as b-1 for s in 0..6, and as b + (P mod 8) - 1 for s = 7.
- R5: The compare value written at the match that begins segment s belongs to segment (s+1) mod 8.
- R6: For segment s, let start = s*b. Let end = P when s = 7 and start+b otherwise. The compare value is all ones (2^(TW+1)-1, above any period value) when the high time H >= end. It is H-start when start < H < end, and 0 when H <= start. A pulse that ends exactly on a segment boundary therefore gives 0 in the following segment.
- R7: A high time of zero gives a compare value of 0 in every segment.
- R8: A high time at or above the total period gives the all-ones compare value in every segment.
- R9: `tgt_period` and `tgt_high` are sampled only at the match that begins segment 7. That pair sets the compare value for segment 0 written at that match. It also sets every period and compare write from the next match up to and including the period write for the next segment 7. Target changes at any other time have no effect on any write.
- R10: After reset, until the first sample, the pair DEF_PERIOD / DEF_HIGH (1250 / 0) is in force.
- R11: With P = 1250 and H = 875, the period values are 155 seven times and then 157. The compare values for segments 0..5 are all-ones, all-ones, all-ones, all-ones, all-ones, 95, and segments 6 and 7 get 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| seg_match | input | 1 | Period-match event from the timer, one cycle per event |
| tgt_period | input | PW | Total output period in prescaled ticks |
| tgt_high | input | PW | High time in prescaled ticks |
| per_wr | output | 1 | Period register write strobe |
| per_val | output | TW | Period register value (segment length minus one) |
| duty_wr | output | 1 | Compare register write strobe |
| duty_val | output | TW+1 | Compare value for the following segment |
| seg_idx | output | 3 | Index of the segment now running |

## Verification
The bench targets a pulse that ends exactly on a segment boundary, where a design with an off-by-one comparison would leave the output high into the next segment. It also targets a pulse ending inside the longer last segment, where a design that assumes equal segments would write a residue that is too large or would hold the output high. High times of zero and of the full period are driven as well: they catch a design that leaks a residue or drops the hold value. The bench changes the targets in the middle of a period and sends back-to-back matches, which exposes a design that samples targets at the wrong segment or that applies a compare value to the segment it is written in rather than to the next one.

// File: rtl/seg_pwm_pkg.sv
package seg_pwm_pkg;
    parameter int unsigned SEG_BITS = 3;
    parameter int unsigned NSEG     = 1 << SEG_BITS;

    typedef logic [SEG_BITS-1:0] seg_idx_t;

    localparam seg_idx_t LAST_SEG = seg_idx_t'(NSEG - 1);
endpackage

// File: rtl/seg_len_calc.sv
// Reload value of the timer period register for one segment.
module seg_len_calc
    import seg_pwm_pkg::*;
#(
    parameter int unsigned PW = 16,
    parameter int unsigned TW = 8
) (
    input  logic [PW-1:0] period,
    input  seg_idx_t      seg,
    output logic [TW-1:0] reload
);
    logic [PW-1:0] base;
    logic [PW-1:0] spare;
    logic [PW-1:0] len;

    always_comb begin
        base   = period >> SEG_BITS;
        spare  = period & PW'(NSEG - 1);
        len    = (seg == LAST_SEG) ? PW'(base + spare) : base;
        reload = TW'(len - 1'b1);
    end
endmodule

// File: rtl/seg_duty_calc.sv
// Compare value for one segment: hold, residue or zero.
module seg_duty_calc
    import seg_pwm_pkg::*;
#(
    parameter int unsigned PW = 16,
    parameter int unsigned TW = 8,
    localparam int unsigned DW = TW + 1
) (
    input  logic [PW-1:0] period,
    input  logic [PW-1:0] high,
    input  seg_idx_t      seg,
    output logic [DW-1:0] duty
);
    localparam logic [DW-1:0] HOLD = {DW{1'b1}};

    logic [PW-1:0] base;
    logic [PW-1:0] start;
    logic [PW-1:0] stop;

    always_comb begin
        base  = period >> SEG_BITS;
        start = PW'(base * PW'(seg));
        stop  = (seg == LAST_SEG) ? period : PW'(start + base);
        if (high >= stop) begin
            duty = HOLD;
        end else if (high > start) begin
            duty = DW'(high - start);
        end else begin
            duty = '0;
        end
    end
endmodule

// File: rtl/seg_pwm_sequencer.sv
module seg_pwm_sequencer
    import seg_pwm_pkg::*;
#(
    parameter int unsigned PW          = 16,
    parameter int unsigned TW          = 8,
    parameter int unsigned DEF_PERIOD  = 1250,
    parameter int unsigned DEF_HIGH    = 0,
    localparam int unsigned DW         = TW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          seg_match,
    input  logic [PW-1:0] tgt_period,
    input  logic [PW-1:0] tgt_high,
    output logic          per_wr,
    output logic [TW-1:0] per_val,
    output logic          duty_wr,
    output logic [DW-1:0] duty_val,
    output logic [2:0]    seg_idx
);
    typedef struct packed {
        seg_idx_t      seg;
        logic [PW-1:0] act_p;
        logic [PW-1:0] act_h;
        logic [PW-1:0] nxt_p;
        logic [PW-1:0] nxt_h;
        logic          per_wr;
        logic [TW-1:0] per_val;
        logic          duty_wr;
        logic [DW-1:0] duty_val;
    } st_t;

    st_t st_d, st_q;

    seg_idx_t      seg_next;
    seg_idx_t      duty_seg;
    logic [PW-1:0] len_p_sel;
    logic [PW-1:0] duty_p_sel;
    logic [PW-1:0] duty_h_sel;
    logic [TW-1:0] reload_w;
    logic [DW-1:0] duty_w;

    // Operand selection: entering segment 0 promotes the sampled pair,
    // entering the last segment samples the inputs for the next period.
    always_comb begin
        seg_next = st_q.seg + 1'b1;
        duty_seg = seg_next + 1'b1;
        len_p_sel = (seg_next == '0) ? st_q.nxt_p : st_q.act_p;
        if (seg_next == LAST_SEG) begin
            duty_p_sel = tgt_period;
            duty_h_sel = tgt_high;
        end else if (seg_next == '0) begin
            duty_p_sel = st_q.nxt_p;
            duty_h_sel = st_q.nxt_h;
        end else begin
            duty_p_sel = st_q.act_p;
            duty_h_sel = st_q.act_h;
        end
    end

    seg_len_calc #(.PW(PW), .TW(TW)) u_len (
        .period (len_p_sel),
        .seg    (seg_next),
        .reload (reload_w)
    );

    seg_duty_calc #(.PW(PW), .TW(TW)) u_duty (
        .period (duty_p_sel),
        .high   (duty_h_sel),
        .seg    (duty_seg),
        .duty   (duty_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.per_wr  = 1'b0;
        st_d.duty_wr = 1'b0;
        if (seg_match) begin
            st_d.seg      = seg_next;
            st_d.per_wr   = 1'b1;
            st_d.per_val  = reload_w;
            st_d.duty_wr  = 1'b1;
            st_d.duty_val = duty_w;
            if (seg_next == LAST_SEG) begin
                st_d.nxt_p = tgt_period;
                st_d.nxt_h = tgt_high;
            end
            if (seg_next == '0) begin
                st_d.act_p = st_q.nxt_p;
                st_d.act_h = st_q.nxt_h;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seg      <= LAST_SEG;
            st_q.act_p    <= PW'(DEF_PERIOD);
            st_q.act_h    <= PW'(DEF_HIGH);
            st_q.nxt_p    <= PW'(DEF_PERIOD);
            st_q.nxt_h    <= PW'(DEF_HIGH);
            st_q.per_wr   <= 1'b0;
            st_q.per_val  <= '0;
            st_q.duty_wr  <= 1'b0;
            st_q.duty_val <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign per_wr   = st_q.per_wr;
    assign per_val  = st_q.per_val;
    assign duty_wr  = st_q.duty_wr;
    assign duty_val = st_q.duty_val;
    assign seg_idx  = 3'(st_q.seg);
endmodule

// File: rtl/seg_pwm_sequencer_chk.sv
module seg_pwm_sequencer_chk #(
    parameter int unsigned TW = 8,
    localparam int unsigned DW = TW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          seg_match,
    input logic          per_wr,
    input logic [TW-1:0] per_val,
    input logic          duty_wr,
    input logic [DW-1:0] duty_val,
    input logic [2:0]    seg_idx
);
    localparam logic [DW-1:0] HOLD = {DW{1'b1}};

    // R1: idle outputs while reset is held
    always @(negedge clk) begin
        if (!rst_n) begin
            p_reset_idle_r1: assert (!per_wr && !duty_wr && seg_idx == 3'd7);
        end
    end

    p_strobe_after_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seg_match |=> (per_wr && duty_wr));

    p_no_stray_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_match |=> (!per_wr && !duty_wr));

    p_values_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_match |=> ($stable(per_val) && $stable(duty_val)));

    p_seg_advance_r3: assert property (@(posedge clk) disable iff (!rst_n)
        seg_match |=> (seg_idx == 3'($past(seg_idx) + 3'd1)));

    p_seg_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !seg_match |=> $stable(seg_idx));

    // R6: a non-hold compare value never exceeds a period register range
    p_residue_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_wr && duty_val != HOLD) |-> (duty_val[DW-1] == 1'b0));
endmodule

bind seg_pwm_sequencer seg_pwm_sequencer_chk #(.TW(TW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .seg_match (seg_match),
    .per_wr    (per_wr),
    .per_val   (per_val),
    .duty_wr   (duty_wr),
    .duty_val  (duty_val),
    .seg_idx   (seg_idx)
);

// File: tb/seg_pwm_sequencer_test.sv
`timescale 1ns/1ps
module seg_pwm_sequencer_test;
    localparam int PW = 16;
    localparam int TW = 8;
    localparam int HOLDV = 511;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          seg_match = 1'b0;
    logic [PW-1:0] tgt_period = '0;
    logic [PW-1:0] tgt_high = '0;
    logic          per_wr;
    logic [TW-1:0] per_val;
    logic          duty_wr;
    logic [TW:0]   duty_val;
    logic [2:0]    seg_idx;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    seg_pwm_sequencer #(.PW(PW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .seg_match(seg_match),
        .tgt_period(tgt_period), .tgt_high(tgt_high),
        .per_wr(per_wr), .per_val(per_val),
        .duty_wr(duty_wr), .duty_val(duty_val), .seg_idx(seg_idx)
    );

    // Behavioural reference model
    int m_seg = 7, a_p = 1250, a_h = 0, n_p = 1250, n_h = 0;
    int e_per = 0, e_duty = 0;
    bit e_pwr = 0, e_dwr = 0;

    function automatic int m_reload(int p, int s);
        int b = p / 8;
        int len = (s == 7) ? b + p % 8 : b;
        return (len - 1) & 255;
    endfunction

    function automatic int m_duty(int p, int h, int s);
        int b = p / 8;
        int st = s * b;
        int en = (s == 7) ? p : st + b;
        if (h >= en) return HOLDV;
        if (h > st) return h - st;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_seg = 7; a_p = 1250; a_h = 0; n_p = 1250; n_h = 0;
            e_per = 0; e_duty = 0; e_pwr = 0; e_dwr = 0;
        end else begin
            e_pwr = 0; e_dwr = 0;
            if (seg_match) begin
                m_seg = (m_seg + 1) % 8;
                if (m_seg == 0) begin a_p = n_p; a_h = n_h; end
                e_pwr = 1; e_dwr = 1;
                e_per = m_reload(a_p, m_seg);
                if (m_seg == 7) begin
                    n_p = int'(tgt_period); n_h = int'(tgt_high);
                    e_duty = m_duty(n_p, n_h, 0);
                end else begin
                    e_duty = m_duty(a_p, a_h, (m_seg + 1) % 8);
                end
            end
        end
    end

    // Per-clock comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            compared++;
            if (per_wr !== e_pwr || duty_wr !== e_dwr) begin
                mismatched++;
                $display("FAIL R2 strobes: actual %b/%b expected %b/%b", per_wr, duty_wr, e_pwr, e_dwr);
            end else if (int'(seg_idx) != m_seg) begin
                mismatched++;
                $display("FAIL R3 seg_idx: actual %0d expected %0d", seg_idx, m_seg);
            end else if (int'(per_val) != e_per) begin
                mismatched++;
                $display("FAIL R4 per_val: actual %0d expected %0d", per_val, e_per);
            end else if (int'(duty_val) != e_duty) begin
                mismatched++;
                $display("FAIL R5/R6/R9 duty_val: actual %0d expected %0d", duty_val, e_duty);
            end
        end
    end

    task automatic chk(input int act, input int exp, input string req);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Leaves at the negedge where the resulting strobes are visible
    task automatic pulse(input int len);
        @(negedge clk);
        seg_match = 1'b1;
        repeat (len) @(negedge clk);
        seg_match = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic run_period(input int p, input int h);
        tgt_period = PW'(p);
        tgt_high = PW'(h);
        for (int k = 0; k < 8; k++) begin
            pulse(1);
            idle(k % 3);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            mismatched++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            finish_run();
        end
    end

    int exp_duty[8] = '{HOLDV, HOLDV, HOLDV, HOLDV, 95, 0, 0, HOLDV};

    initial begin
        idle(3);
        chk(int'(per_wr) + int'(duty_wr), 0, "R1 strobes in reset");
        chk(int'(seg_idx), 7, "R1 seg in reset");
        rst_n = 1'b1;
        tgt_period = 16'd1250;
        tgt_high = 16'd875;
        idle(3);
        chk(int'(per_wr), 0, "R1 no write before match");

        // R10: defaults govern the first output period
        for (int k = 0; k < 7; k++) begin
            pulse(1);
            chk(int'(per_val), 155, "R10 default period");
            chk(int'(duty_val), 0, "R10 default high");
            idle(1);
        end
        pulse(1);
        chk(int'(per_val), 157, "R4 last segment default");
        chk(int'(duty_val), HOLDV, "R9 sample at segment 7");
        tgt_period = 16'd2000;
        tgt_high = 16'd300;

        // R11: 1250 / 875 worked case, inputs changed mid-period (R9)
        for (int k = 0; k < 8; k++) begin
            pulse(1);
            chk(int'(seg_idx), k, "R3 index");
            chk(int'(per_val), (k == 7) ? 157 : 155, "R11 period");
            chk(int'(duty_val), exp_duty[k], "R11 duty");
            idle(2);
        end

        // R8 then R7 as active periods
        run_period(100, 100);
        tgt_period = 16'd100;
        tgt_high = 16'd0;
        for (int k = 0; k < 8; k++) begin
            pulse(1);
            if (k < 7) chk(int'(duty_val), HOLDV, "R8 full high");
            else chk(int'(duty_val), 0, "R7 zero high sampled");
            idle(1);
        end
        tgt_period = 16'd800;
        tgt_high = 16'd300;
        for (int k = 0; k < 8; k++) begin
            pulse(1);
            if (k < 7) chk(int'(duty_val), 0, "R7 zero high");
            idle(1);
        end

        // R6 boundary: 800/300 active, pulse ends exactly at segment 3 start
        run_period(1250, 1249);
        run_period(8, 4);
        run_period(2047, 1000);
        // R5: back-to-back matches
        tgt_period = 16'd640;
        tgt_high = 16'd500;
        for (int k = 0; k < 8; k++) begin
            pulse(2);
            idle(1);
        end

        for (int r = 0; r < 400; r++) begin
            tgt_period = PW'(8 + $urandom_range(0, 1900));
            tgt_high = PW'($urandom_range(0, int'(tgt_period) + 20));
            pulse(1 + (r % 2));
            idle(r % 3);
        end
        idle(4);
        finish_run();
    end
endmodule